// File: doc/BRIEF.md
# Synchronous Charge-Balance Pulse Modulator

This block is a digital model of a synchronous voltage-to-frequency converter. A signed input code stands for the ratio of an input level to a reference. Every clock cycle the block decides whether to emit one output pulse, so that the average pulse rate is a fixed linear function of the code. The rate runs from one tenth of the clock rate at code zero to nine tenths at full scale. Because the output is tied to the clock, a pulse counter that is gated by a divided version of the same clock reads the code back exactly.

The core is a first-order accumulator. Each cycle it adds an increment of (0.1 + 0.8·code/full-scale) of its modulus. When the sum reaches the modulus, a pulse is emitted and the modulus is subtracted. This is the digital form of an integrator whose charge is kept in balance by a comparator and a one-bit feedback path. The code is registered on entry, and a small overrange on both sides of the nominal span is accepted. The decision appears as a registered one-cycle strobe. A gated copy of the strobe is high only during the clock-high half of its cycle.

Top module: `vfc_modulator`

## Requirements
- R1: With code 0 (zero scale), the strobe averages 0.1 of the clock rate (100 ±1 pulses per 1000 cycles). While code 0 is held, two strobes are never adjacent.
- R2: With code FS_CODE (1024 by default, full scale), the strobe averages 0.9 of the clock rate (900 ±1 per 1000). While it is held, no two consecutive cycles are both without a strobe.
- R3: The rate is linear in the code. It equals (FS_CODE + 8·c)/(10·FS_CODE) of the clock rate for the clamped code c. Half scale (512) gives 500 ±1 per 1000, and one-eighth scale (128) gives 200 ±1.
- R4: Quarter scale (256) averages 300 ±1 per 1000. The distance between successive strobes is always 3 or 4 cycles.
- R5: The strobe is a registered signal. pulse_out equals the strobe while the clock is high and is 0 while the clock is low, so each pulse starts on a rising edge and lasts one clock-high period.
- R6: Codes are clamped to the range -OVR_CODE to FS_CODE+OVR_CODE (-61 to 1085 by default). With -61 the rate is about 0.052 (52 ±1 per 1000), and with 1085 it is about 0.948 (947 ±1). Codes beyond these limits give the same rate as the limit. The gap between strobes never exceeds 20 cycles.
- R7: A code present at rising edge n is used for the strobe decision made at edge n+1. After a step, the new rate therefore holds from the second edge on.
- R8: While rst (synchronous, active high) is sampled high, the strobe and pulse_out are 0 and the accumulator is loaded with half the modulus. The entry register is cleared to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also gates pulse_out |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | CODE_W (12) | Signed input code, two's complement |
| pulse_strobe | output | 1 | Registered one-cycle pulse decision |
| pulse_out | output | 1 | Strobe gated to the clock-high half cycle |

## Verification
The hardest situations to reach are the exact pulse spacing and the step boundary. Both depend on the hidden accumulator phase, which the ports cannot set directly. The bench therefore keeps its own accumulator model from reset onward and compares the strobe with it on every cycle. This makes each step land at a phase the model knows. The bench applies codes far beyond the clamp limits and long holds at each scale point, and it measures pulse counts and spacings over fixed windows to confirm the rates and the 3/4-cycle alternation.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  // Clamp a value into [lo, hi].
  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/vfc_increment.sv
module vfc_increment #(
  parameter int CODE_W   = 12,
  parameter int FS_CODE  = 1024,
  parameter int OVR_CODE = 61,
  parameter int ACC_W    = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [CODE_W-1:0] code_in,
  output logic        [ACC_W-1:0]  inc_o
);
  import vfc_pkg::*;

  localparam int MOD     = 10 * FS_CODE;
  localparam int CODE_LO = -OVR_CODE;
  localparam int CODE_HI = FS_CODE + OVR_CODE;

  logic signed [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_in;
  end

  int code_c;
  int inc_c;

  always_comb begin
    code_c = clamp_int(int'(code_q), CODE_LO, CODE_HI);
    inc_c  = clamp_int(FS_CODE + 8 * code_c, 0, MOD);
    inc_o  = ACC_W'(inc_c);
  end
endmodule

// File: rtl/vfc_accum.sv
module vfc_accum #(
  parameter int ACC_W = 16,
  parameter int MOD   = 10240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam logic [ACC_W-1:0] MOD_V  = ACC_W'(MOD);
  localparam logic [ACC_W-1:0] HALF_V = ACC_W'(MOD / 2);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_c;
  logic             hit_c;
  logic             ovf_q;

  always_comb begin
    sum_c = acc_q + inc_i;
    hit_c = (sum_c >= MOD_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= HALF_V;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= hit_c ? (sum_c - MOD_V) : sum_c;
      ovf_q <= hit_c;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/vfc_gate.sv
module vfc_gate (
  input  logic clk,
  input  logic strobe_i,
  output logic pulse_o
);
  // Strobe is registered on the rising edge; ANDing with the clock
  // confines the pulse to the high half of that same cycle.
  assign pulse_o = strobe_i & clk;
endmodule

// File: rtl/vfc_modulator.sv
module vfc_modulator #(
  parameter int CODE_W   = 12,
  parameter int FS_CODE  = 1024,
  parameter int OVR_CODE = 61
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [CODE_W-1:0] code_in,
  output logic                     pulse_strobe,
  output logic                     pulse_out
);
  localparam int MOD   = 10 * FS_CODE;
  localparam int ACC_W = $clog2(2 * MOD) + 1;

  logic [ACC_W-1:0] inc_w;
  logic [ACC_W-1:0] acc_q;

  vfc_increment #(
    .CODE_W(CODE_W), .FS_CODE(FS_CODE), .OVR_CODE(OVR_CODE), .ACC_W(ACC_W)
  ) u_inc (
    .clk(clk), .rst(rst), .code_in(code_in), .inc_o(inc_w)
  );

  vfc_accum #(.ACC_W(ACC_W), .MOD(MOD)) u_acc (
    .clk(clk), .rst(rst), .inc_i(inc_w), .acc_o(acc_q), .ovf_o(pulse_strobe)
  );

  vfc_gate u_gate (.clk(clk), .strobe_i(pulse_strobe), .pulse_o(pulse_out));
endmodule

// File: rtl/vfc_modulator_chk.sv
module vfc_modulator_chk #(
  parameter int CODE_W  = 12,
  parameter int FS_CODE = 1024,
  parameter int ACC_W   = 16,
  parameter int MOD     = 10240
) (
  input logic                     clk,
  input logic                     rst,
  input logic signed [CODE_W-1:0] code_in,
  input logic                     pulse_strobe,
  input logic [ACC_W-1:0]         acc
);
  localparam int MAX_GAP = 20;

  logic [7:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || pulse_strobe) gap_q <= '0;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc == ACC_W'(MOD / 2) && !pulse_strobe)); // R8

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    acc < ACC_W'(MOD)); // R6

  AST_GAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(gap_q) <= MAX_GAP); // R6

  AST_FS_NO_DOUBLE_MISS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) &&
     $signed($past(code_in, 2)) == FS_CODE && $signed($past(code_in, 3)) == FS_CODE &&
     !$past(pulse_strobe)) |-> pulse_strobe); // R2

  AST_ZS_NO_DOUBLE_HIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) &&
     $past(code_in, 2) == '0 && $past(code_in, 3) == '0 &&
     $past(pulse_strobe)) |-> !pulse_strobe); // R1
endmodule

bind vfc_modulator vfc_modulator_chk #(
  .CODE_W(CODE_W), .FS_CODE(FS_CODE), .ACC_W(ACC_W), .MOD(MOD)
) u_chk (
  .clk(clk), .rst(rst), .code_in(code_in), .pulse_strobe(pulse_strobe), .acc(acc_q)
);

// File: tb/tb_vfc_modulator.sv
module tb_vfc_modulator;
  localparam int CODE_W = 12;
  localparam int FS     = 1024;
  localparam int OVR    = 61;
  localparam int MODV   = 10 * FS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [CODE_W-1:0] code_in = '0;
  logic pulse_strobe, pulse_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  vfc_modulator #(.CODE_W(CODE_W), .FS_CODE(FS), .OVR_CODE(OVR)) dut (
    .clk(clk), .rst(rst), .code_in(code_in),
    .pulse_strobe(pulse_strobe), .pulse_out(pulse_out)
  );

  always #2 clk = ~clk;

  // Rate law from the requirements (R3, R6).
  function automatic int rate_inc(input int c);
    int cc;
    cc = (c < -OVR) ? -OVR : ((c > FS + OVR) ? FS + OVR : c);
    return FS + 8 * cc;
  endfunction

  // Behavioural reference: accumulator value, pending code, last decision.
  int  m_acc = MODV / 2;
  int  m_code = 0;
  bit  m_str = 1'b0;

  always @(posedge clk) begin
    int s;
    if (rst) begin
      m_acc = MODV / 2; m_str = 1'b0; m_code = 0;
    end else begin
      s = m_acc + rate_inc(m_code);
      m_str = (s >= MODV);
      m_acc = m_str ? s - MODV : s;
      m_code = int'(code_in);
    end
    #1;
    if (!done) begin
      checks++;
      if (pulse_out !== m_str || pulse_strobe !== m_str) begin
        fails++;
        $display("FAIL R5/R7 high-phase: strobe=%0b out=%0b expected %0b", pulse_strobe, pulse_out, m_str);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pulse_out !== 1'b0 || pulse_strobe !== m_str) begin
        fails++;
        $display("FAIL R5 low-phase: strobe=%0b out=%0b expected strobe %0b out 0", pulse_strobe, pulse_out, m_str);
      end
    end
  end

  task automatic check_eq(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // Apply a code, settle, then count strobes over n cycles.
  task automatic measure(input int c, input int n, output int cnt, output int bad_gap);
    int gap; bit seen;
    @(negedge clk); code_in = CODE_W'(c);
    repeat (4) @(negedge clk);
    cnt = 0; bad_gap = 0; gap = 0; seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      gap++;
      if (pulse_strobe) begin
        if (seen && gap != 3 && gap != 4) bad_gap++;
        cnt++; seen = 1'b1; gap = 0;
      end
    end
  endtask

  task automatic rate_check(input string req, input int c);
    int cnt, bg, e;
    e = rate_inc(c) * 1000 / MODV;
    measure(c, 1000, cnt, bg);
    check_eq(req, cnt, e - 1, e + 1);
  endtask

  initial begin
    int cnt, bg, cnt2;
    // R8: reset holds outputs low
    repeat (3) @(negedge clk);
    check_eq("R8 strobe in reset", int'(pulse_strobe), 0, 0);
    #3; check_eq("R8 out in reset (clk high)", int'(pulse_out), 0, 0);
    @(negedge clk); rst = 1'b0;

    rate_check("R1 zero scale", 0);
    rate_check("R2 full scale", FS);
    rate_check("R3 half scale", FS / 2);
    rate_check("R3 eighth scale", FS / 8);

    measure(FS / 4, 1000, cnt, bg);
    check_eq("R4 quarter rate", cnt, 299, 301);
    check_eq("R4 spacing 3/4", bg, 0, 0);

    rate_check("R6 low overrange", -OVR);
    rate_check("R6 high overrange", FS + OVR);
    measure(-OVR, 1000, cnt, bg);
    measure(-1500, 1000, cnt2, bg);
    check_eq("R6 clamp below", cnt2, cnt - 1, cnt + 1);
    measure(FS + OVR, 1000, cnt, bg);
    measure(2047, 1000, cnt2, bg);
    check_eq("R6 clamp above", cnt2, cnt - 1, cnt + 1);

    // R7: step from zero to full scale; decisions 2..11 follow new code.
    @(negedge clk); code_in = '0;
    repeat (30) @(negedge clk);
    code_in = CODE_W'(FS);
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pulse_strobe) cnt++;
    end
    check_eq("R7 step settling", cnt, 8, 10);

    // R8: reset again mid-run, accumulator returns to half modulus.
    @(negedge clk); rst = 1'b1; code_in = CODE_W'(FS / 2);
    @(negedge clk);
    check_eq("R8 strobe after reset", int'(pulse_strobe), 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R8 first decision uses code 0", int'(pulse_strobe), 0, 0);
    @(negedge clk);
    check_eq("R8 half-modulus start pulses at once", int'(pulse_strobe), 1, 1);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule